// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block gathers the activation requests of a sixteen-channel DMA controller and decides which channel the transfer engine serves next. A channel becomes pending through any of three sources: a software start pulse that sets a sticky bit, a link pulse from another channel's completion that is also held in a sticky bit, or the channel's peripheral request line. The peripheral line counts only while that channel's request enable is set, and it is never latched.

Whenever the engine signals idle and at least one channel is pending, the block picks one winner and registers it as a one-cycle grant pulse with the channel number. The same edge clears the winner's sticky software and link bits. The winner is chosen by unique programmable priorities, or by a rotating search that starts just after the last granted channel. A mode input picks between the two on every decision. The block also ORs the enabled per-channel error flags into one error interrupt. It holds a sticky completion interrupt per channel, which is set when that channel's major loop ends with its interrupt enabled.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_valid`, `err_irq` and every `done_irq` bit are 0, and no sticky request is held. An idle engine with no peripheral request receives no grant.
- R2: A pulse on `sw_start_set[n]` makes channel n pending until it is granted. The grant clears that pending state, so a later idle cycle with no new request gives no further grant.
- R3: `hw_req[n]` makes channel n pending only in cycles where `hw_req_en[n]` is 1. It is not latched: once it drops before an idle cycle, no grant follows.
- R4: A pulse on `link_req[n]` is held while the engine is busy. The channel is granted exactly once at a later idle cycle.
- R5: A grant is decided only in a cycle with `engine_idle` = 1. `grant_valid` is 1 in the following cycle for exactly that decision, and `grant_ch` is below the channel count.
- R6: In fixed mode (`rr_mode` = 0), the pending channel with the numerically highest 4-bit priority wins. Channel n's priority is `ch_prio[4n+3:4n]`.
- R7: In round-robin mode (`rr_mode` = 1), the search starts at the channel after the last granted one and wraps from 15 to 0. After reset the search starts at channel 0.
- R8: A change of `rr_mode` applies from the next decision onward. Without a new grant, `grant_ch` keeps its value.
- R9: `err_irq` is 1 one cycle after any channel has both `err_flag[n]` and `err_int_en[n]` at 1, and is 0 one cycle after none does.
- R10: `done_irq[n]` is set one cycle after `major_done[n]` arrives with `done_int_en[n]` = 1. It stays set until `irq_clr[n]`. A set and a clear in the same cycle leave it set.
- R11: A software start pulse that arrives in the same cycle as the grant of its channel is kept, so the channel is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start_set | input | 16 | Software start pulses, one per channel |
| link_req | input | 16 | Channel link pulses, one per channel |
| hw_req | input | 16 | Peripheral request lines |
| hw_req_en | input | 16 | Peripheral request enables |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round robin |
| ch_prio | input | 64 | Four-bit priority per channel |
| engine_idle | input | 1 | Transfer engine can accept a grant |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_ch | output | 4 | Granted channel number |
| err_flag | input | 16 | Per-channel error flags |
| err_int_en | input | 16 | Per-channel error interrupt enables |
| err_irq | output | 1 | Summed error interrupt |
| major_done | input | 16 | Major-loop completion pulses |
| done_int_en | input | 16 | Completion interrupt enables |
| irq_clr | input | 16 | Completion interrupt clears |
| done_irq | output | 16 | Per-channel completion interrupts |

## Verification
The assertions check the rules that hold on every cycle:
- a grant is preceded by an idle cycle and by a pending request on the granted channel;
- the channel number holds between grants;
- the summed error interrupt follows its enabled flags;
- completion interrupts never drop without a clear.

Which channel wins under each mode, the rotation and its wrap, latching of link and software requests across busy periods, and the same-cycle set/clear cases need the bench's scenarios. Only a chosen input history shows those.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int DEF_NUM_CH = 16;
    localparam int DEF_PRIO_W = 4;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sw_set,
    input  logic [NUM_CH-1:0] link_set,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] hw_en,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] pend
);
    typedef struct packed {
        logic [NUM_CH-1:0] sw;
        logic [NUM_CH-1:0] link;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new pulse wins over the grant clear of the same cycle
        st_d.sw   = (st_q.sw   & ~clr_vec) | sw_set;
        st_d.link = (st_q.link & ~clr_vec) | link_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_pend
        assign pend[n] = st_q.sw[n] | st_q.link[n] | (hw_req[n] & hw_en[n]);
    end
endmodule

// File: rtl/dma_fixed_pick.sv
module dma_fixed_pick #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        pend,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     found,
    output logic [CH_W-1:0]          ch
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found  = 1'b0;
        ch     = '0;
        best_p = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best_p)) begin
                found  = 1'b1;
                ch     = CH_W'(i);
                best_p = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] pend,
    input  logic [CH_W-1:0]   last,
    output logic              found,
    output logic [CH_W-1:0]   ch
);
    logic [CH_W:0] idx;

    always_comb begin
        found = 1'b0;
        ch    = '0;
        idx   = '0;
        for (int k = 1; k <= NUM_CH; k++) begin
            idx = {1'b0, last} + (CH_W+1)'(k);
            if (idx >= (CH_W+1)'(NUM_CH)) idx = idx - (CH_W+1)'(NUM_CH);
            if (!found && pend[idx[CH_W-1:0]]) begin
                found = 1'b1;
                ch    = idx[CH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] err_flag,
    input  logic [NUM_CH-1:0] err_en,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic [NUM_CH-1:0] done_en,
    input  logic [NUM_CH-1:0] clr,
    output logic              err_irq,
    output logic [NUM_CH-1:0] done_irq
);
    typedef struct packed {
        logic              err;
        logic [NUM_CH-1:0] done;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.err  = |(err_flag & err_en);
        st_d.done = (st_q.done & ~clr) | (done_pulse & done_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_irq  = st_q.err;
    assign done_irq = st_q.done;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int PRIO_W = DEF_PRIO_W,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        sw_start_set,
    input  logic [NUM_CH-1:0]        link_req,
    input  logic [NUM_CH-1:0]        hw_req,
    input  logic [NUM_CH-1:0]        hw_req_en,
    input  logic                     rr_mode,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic                     engine_idle,
    output logic                     grant_valid,
    output logic [CH_W-1:0]          grant_ch,
    input  logic [NUM_CH-1:0]        err_flag,
    input  logic [NUM_CH-1:0]        err_int_en,
    output logic                     err_irq,
    input  logic [NUM_CH-1:0]        major_done,
    input  logic [NUM_CH-1:0]        done_int_en,
    input  logic [NUM_CH-1:0]        irq_clr,
    output logic [NUM_CH-1:0]        done_irq
);
    typedef struct packed {
        logic            gv;
        logic [CH_W-1:0] gch;
        logic [CH_W-1:0] last;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_CH-1:0] pend_vec;
    logic [NUM_CH-1:0] clr_vec;
    logic              fx_found, rr_found, win_found;
    logic [CH_W-1:0]   fx_ch, rr_ch, win_ch;
    logic              take;
    arb_mode_e         mode;

    assign mode = arb_mode_e'(rr_mode);

    dma_req_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_set   (sw_start_set),
        .link_set (link_req),
        .hw_req   (hw_req),
        .hw_en    (hw_req_en),
        .clr_vec  (clr_vec),
        .pend     (pend_vec)
    );

    dma_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
        .pend      (pend_vec),
        .prio_flat (ch_prio),
        .found     (fx_found),
        .ch        (fx_ch)
    );

    dma_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
        .pend  (pend_vec),
        .last  (st_q.last),
        .found (rr_found),
        .ch    (rr_ch)
    );

    dma_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_flag   (err_flag),
        .err_en     (err_int_en),
        .done_pulse (major_done),
        .done_en    (done_int_en),
        .clr        (irq_clr),
        .err_irq    (err_irq),
        .done_irq   (done_irq)
    );

    always_comb begin
        win_found = (mode == ARB_ROUND) ? rr_found : fx_found;
        win_ch    = (mode == ARB_ROUND) ? rr_ch    : fx_ch;
        take      = engine_idle && win_found;

        clr_vec = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (take && win_ch == CH_W'(n)) clr_vec[n] = 1'b1;
        end

        st_d    = st_q;
        st_d.gv = take;
        if (take) begin
            st_d.gch  = win_ch;
            st_d.last = win_ch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= CH_W'(NUM_CH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gv;
    assign grant_ch    = st_q.gch;
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              engine_idle,
    input logic [NUM_CH-1:0] pend_vec,
    input logic              grant_valid,
    input logic [CH_W-1:0]   grant_ch,
    input logic [NUM_CH-1:0] err_flag,
    input logic [NUM_CH-1:0] err_int_en,
    input logic              err_irq,
    input logic [NUM_CH-1:0] irq_clr,
    input logic [NUM_CH-1:0] done_irq
);
    logic [NUM_CH-1:0] pend_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= pend_vec;
    end

    p_grant_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(engine_idle));

    p_grant_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (32'(grant_ch) < NUM_CH));

    p_grant_was_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pend_prev[grant_ch]);

    p_ch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> $stable(grant_ch));

    p_err_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_flag & err_int_en)) |=> err_irq);

    p_err_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(err_flag & err_int_en)) |=> !err_irq);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(done_irq) & ~$past(irq_clr) & ~done_irq) == '0));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .engine_idle (engine_idle),
    .pend_vec    (pend_vec),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch),
    .err_flag    (err_flag),
    .err_int_en  (err_int_en),
    .err_irq     (err_irq),
    .irq_clr     (irq_clr),
    .done_irq    (done_irq)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw_start_set = '0, link_req = '0, hw_req = '0, hw_req_en = '0;
    logic        rr_mode = 1'b0;
    logic [63:0] ch_prio;
    logic        engine_idle = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_ch;
    logic [15:0] err_flag = '0, err_int_en = '0, major_done = '0, done_int_en = '0, irq_clr = '0;
    logic        err_irq;
    logic [15:0] done_irq;

    int n_tests = 0;
    int n_fail  = 0;
    int last_g  = 15;

    always #10 clk = ~clk;

    dma_req_arbiter i_dma_req_arbiter (
        .clk(clk), .rst_n(rst_n), .sw_start_set(sw_start_set), .link_req(link_req),
        .hw_req(hw_req), .hw_req_en(hw_req_en), .rr_mode(rr_mode), .ch_prio(ch_prio),
        .engine_idle(engine_idle), .grant_valid(grant_valid), .grant_ch(grant_ch),
        .err_flag(err_flag), .err_int_en(err_int_en), .err_irq(err_irq),
        .major_done(major_done), .done_int_en(done_int_en), .irq_clr(irq_clr),
        .done_irq(done_irq)
    );

    typedef struct packed {
        logic [15:0] hw;
        logic [15:0] en;
        logic        v;
        logic [3:0]  ch;
    } vec_t;

    // fixed mode, priority of channel n is n
    localparam vec_t VECS [6] = '{
        '{16'h0005, 16'hFFFF, 1'b1, 4'd2},
        '{16'h8001, 16'h7FFF, 1'b1, 4'd0},
        '{16'hFFFF, 16'h0000, 1'b0, 4'd0},
        '{16'h0F00, 16'h0F00, 1'b1, 4'd11},
        '{16'h0010, 16'h0010, 1'b1, 4'd4},
        '{16'h0000, 16'hFFFF, 1'b0, 4'd0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_grant(string req, bit ev, int ech);
        chk(req, 32'(grant_valid), 32'(ev));
        if (ev) begin
            chk(req, 32'(grant_ch), 32'(ech));
            last_g = ech;
        end
    endtask

    // one idle cycle, then check the resulting grant
    task automatic idle_pulse(string req, bit ev, int ech);
        engine_idle = 1'b1;
        tick();
        engine_idle = 1'b0;
        check_grant(req, ev, ech);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        last_g = 15;
    endtask

    task automatic prio_ident();
        for (int n = 0; n < 16; n++) ch_prio[n*4 +: 4] = 4'(n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        prio_ident();
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 grant_valid", 32'(grant_valid), 0);
        chk("R1 err_irq", 32'(err_irq), 0);
        chk("R1 done_irq", 32'(done_irq), 0);
        idle_pulse("R1 nothing pending", 0, 0);

        // R6 / R3 vector table
        foreach (VECS[i]) begin
            hw_req    = VECS[i].hw;
            hw_req_en = VECS[i].en;
            idle_pulse($sformatf("R6 R3 vector %0d", i), VECS[i].v, int'(VECS[i].ch));
        end
        hw_req = '0;

        // R6 non-monotone priority
        ch_prio[3*4 +: 4]  = 4'd15;
        ch_prio[15*4 +: 4] = 4'd3;
        hw_req = 16'h8008; hw_req_en = 16'hFFFF;
        idle_pulse("R6 swapped priority", 1, 3);
        hw_req = '0;
        prio_ident();

        // R3 peripheral request is not latched
        hw_req = 16'h0080;
        tick();
        hw_req = '0;
        idle_pulse("R3 dropped hw request", 0, 0);

        // R2 software start
        sw_start_set = 16'h0040;
        tick();
        sw_start_set = '0;
        idle_pulse("R2 sw start grant", 1, 6);
        idle_pulse("R2 sw cleared", 0, 0);

        // R5 no grant while busy
        sw_start_set = 16'h0002;
        tick();
        sw_start_set = '0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check_grant("R5 busy no grant", 0, 0);
        end
        idle_pulse("R5 grant on idle", 1, 1);

        // R4 link latched across busy period
        link_req = 16'h0200;
        tick();
        link_req = '0;
        repeat (4) tick();
        idle_pulse("R4 link grant", 1, 9);
        idle_pulse("R4 link cleared", 0, 0);

        // R11 new start in the grant cycle is kept
        sw_start_set = 16'h0020;
        tick();
        engine_idle = 1'b1;
        tick();
        engine_idle = 1'b0;
        sw_start_set = '0;
        check_grant("R11 first grant", 1, 5);
        idle_pulse("R11 regrant", 1, 5);
        idle_pulse("R11 then empty", 0, 0);

        // R7 rotation with wrap, back-to-back grants
        rr_mode = 1'b1; hw_req = 16'hFFFF; hw_req_en = 16'hFFFF;
        engine_idle = 1'b1;
        for (int k = 0; k < 18; k++) begin
            tick();
            check_grant("R7 rotation", 1, (last_g + 1) % 16);
        end
        engine_idle = 1'b0;
        hw_req = '0;
        tick();

        // R8 mode change
        rr_mode = 1'b0; hw_req = 16'h0011;
        idle_pulse("R8 fixed pick", 1, 4);
        rr_mode = 1'b1;
        tick();
        chk("R8 grant_ch held", 32'(grant_ch), 4);
        check_grant("R8 no grant", 0, 0);
        idle_pulse("R8 rr after switch", 1, 0);
        rr_mode = 1'b0;
        idle_pulse("R8 fixed after switch", 1, 4);
        hw_req = '0;

        // R9 error summing
        err_flag = 16'h0100; err_int_en = 16'h00FF;
        tick();
        chk("R9 masked error", 32'(err_irq), 0);
        err_int_en = 16'h0100;
        tick();
        chk("R9 enabled error", 32'(err_irq), 1);
        err_flag = '0;
        tick();
        chk("R9 error gone", 32'(err_irq), 0);

        // R10 completion interrupts
        done_int_en = 16'h0008; major_done = 16'h000C;
        tick();
        major_done = '0;
        chk("R10 done set", 32'(done_irq), 32'h0008);
        tick();
        chk("R10 done sticky", 32'(done_irq), 32'h0008);
        irq_clr = 16'h0008; major_done = 16'h0008;
        tick();
        chk("R10 set beats clear", 32'(done_irq), 32'h0008);
        major_done = '0;
        tick();
        irq_clr = '0;
        chk("R10 cleared", 32'(done_irq), 0);

        // R7 / R1 search starts at 0 after reset
        rr_mode = 1'b1; hw_req = 16'h8001;
        do_reset();
        idle_pulse("R7 start after reset", 1, 0);
        hw_req = '0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule